// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer for a windowed register file. It holds a bitmask that marks invalid windows, with one bit for each window. Software can overwrite the pointer and the mask directly. The rest of the core asks the block to step down one window (save) or up one window (restore). Each step first looks up the bit of the window it would land on. If that bit is set, the step is refused, the pointer stays where it is, and a one-cycle trap flag is raised: overflow for a save, underflow for a restore.

The number of implemented windows is the parameter `NWIN`, from 2 to 32. Moves wrap modulo `NWIN`. Mask bits at or above `NWIN` are ignored. The register file and the trap handlers sit outside the block.

Top module: `win_ptr_ctrl`

## Requirements
- R1: After reset the pointer is 0, the mask is all clear, and both trap flags are 0.
- R2: A save whose target is unmasked sets the pointer to (pointer − 1) mod NWIN on the next cycle, so window 0 goes to window NWIN−1.
- R3: A restore whose target is unmasked sets the pointer to (pointer + 1) mod NWIN on the next cycle, so window NWIN−1 goes to window 0.
- R4: A save whose target window has its mask bit set raises ovf_trap for exactly one cycle, on the next cycle. The pointer keeps its value.
- R5: A restore whose target window has its mask bit set raises unf_trap for exactly one cycle, on the next cycle. The pointer keeps its value.
- R6: Mask bit i belongs to window i. Bits at positions NWIN and above never block a move.
- R7: A pointer write with a value below NWIN takes effect on the next cycle. A written value of NWIN or more is ignored.
- R8: When a pointer write or a mask write (mask_wr_en) arrives in the same cycle as a save or restore, the write is applied and the move is dropped. No trap is raised.
- R9: When save and restore are requested together, only the save is acted on.
- R10: The pointer always stays below NWIN, and the two trap flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| save_req | input | 1 | Request to move down one window |
| restore_req | input | 1 | Request to move up one window |
| ptr_wr_en | input | 1 | Software write strobe for the pointer |
| ptr_wr_data | input | 5 | Value written to the pointer |
| mask_wr_en | input | 1 | Software write strobe for the invalid mask |
| mask_wr_data | input | 32 | Value written to the mask; bit i is window i |
| cur_ptr | output | 5 | Current window pointer |
| ovf_trap | output | 1 | One-cycle pulse: a save was refused |
| unf_trap | output | 1 | One-cycle pulse: a restore was refused |

## Verification
A window move can arrive in the same cycle as a software write to the pointer or to the mask, and a save can arrive together with a restore. Directed cycles raise each of these pairs on purpose, including a write that lands while the move's target window is masked. The bench then checks that the write wins, that no trap appears, and that only the save acts. A random phase then drives these inputs together often. A behavioural model in the bench judges every cycle by comparing the pointer and both trap flags.

// File: rtl/winptr_pkg.sv
package winptr_pkg;
  localparam int PTR_W  = 5;
  localparam int MASK_W = 32;
  typedef logic [PTR_W-1:0]  wptr_t;
  typedef logic [MASK_W-1:0] wmask_t;
  typedef enum logic [1:0] {MV_NONE, MV_SAVE, MV_RESTORE} move_e;
endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q   <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      stage_q   <= 1'b1;
      rst_n_out <= stage_q;
    end
  end
endmodule

// File: rtl/wp_neighbor.sv
module wp_neighbor
  import winptr_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  wptr_t cur,
  output wptr_t below,
  output wptr_t above
);
  localparam wptr_t TOP = wptr_t'(NWIN - 1);

  always_comb begin
    below = (cur == '0)  ? TOP : cur - wptr_t'(1);
    above = (cur == TOP) ? '0  : cur + wptr_t'(1);
  end
endmodule

// File: rtl/wp_mask_lookup.sv
module wp_mask_lookup
  import winptr_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  wmask_t mask_raw,
  input  wptr_t  idx,
  output logic   blocked
);
  wmask_t eff;

  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    if (i < NWIN) begin : g_live
      assign eff[i] = mask_raw[i];
    end else begin : g_dead
      assign eff[i] = 1'b0;
    end
  end

  assign blocked = eff[idx];
endmodule

// File: rtl/win_ptr_ctrl.sv
module win_ptr_ctrl
  import winptr_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        save_req,
  input  logic        restore_req,
  input  logic        ptr_wr_en,
  input  logic [4:0]  ptr_wr_data,
  input  logic        mask_wr_en,
  input  logic [31:0] mask_wr_data,
  output logic [4:0]  cur_ptr,
  output logic        ovf_trap,
  output logic        unf_trap
);
  localparam logic [PTR_W:0] NWIN_L = (PTR_W+1)'(NWIN);

  logic   rst_n_s;
  wptr_t  ptr_q, ptr_d, win_below, win_above, target;
  wmask_t mask_q, mask_d;
  logic   ovf_q, ovf_d, unf_q, unf_d;
  logic   ptr_ld, wr_ok, any_wr, target_blocked;
  move_e  move;

  wp_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  wp_neighbor #(.NWIN(NWIN)) u_nb (
    .cur(ptr_q), .below(win_below), .above(win_above)
  );

  wp_mask_lookup #(.NWIN(NWIN)) u_lk (
    .mask_raw(mask_q), .idx(target), .blocked(target_blocked)
  );

  // next-state logic
  always_comb begin
    any_wr = ptr_wr_en | mask_wr_en;
    wr_ok  = ptr_wr_en && ({1'b0, ptr_wr_data} < NWIN_L);
    if (any_wr)           move = MV_NONE;
    else if (save_req)    move = MV_SAVE;
    else if (restore_req) move = MV_RESTORE;
    else                  move = MV_NONE;
    target = (move == MV_SAVE) ? win_below : win_above;

    ptr_d  = ptr_q;
    mask_d = mask_q;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    ptr_ld = 1'b0;
    if (wr_ok) begin
      ptr_d  = ptr_wr_data;
      ptr_ld = 1'b1;
    end
    if (mask_wr_en) mask_d = mask_wr_data;
    case (move)
      MV_SAVE: begin
        if (target_blocked) ovf_d = 1'b1;
        else begin ptr_d = target; ptr_ld = 1'b1; end
      end
      MV_RESTORE: begin
        if (target_blocked) unf_d = 1'b1;
        else begin ptr_d = target; ptr_ld = 1'b1; end
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ptr_q  <= '0;
      mask_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (ptr_ld)     ptr_q  <= ptr_d;
      if (mask_wr_en) mask_q <= mask_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign cur_ptr  = ptr_q;
  assign ovf_trap = ovf_q;
  assign unf_trap = unf_q;

  // R10
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    {1'b0, cur_ptr} < NWIN_L);

  // R10
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({ovf_trap, unf_trap}));

  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (save_req && !ptr_wr_en && !mask_wr_en) |=> (ovf_trap || cur_ptr != $past(cur_ptr)));

  // R4
  trap_ptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (save_req || restore_req) && !ptr_wr_en && !mask_wr_en |=>
      ((ovf_trap || unf_trap) -> $stable(cur_ptr)));

  // R7
  ptr_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ptr_wr_en && ({1'b0, ptr_wr_data} < NWIN_L)) |=> cur_ptr == $past(ptr_wr_data));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ptr_wr_en || mask_wr_en) |=> (!ovf_trap && !unf_trap));

  // R9
  save_first_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (save_req && restore_req && !ptr_wr_en && !mask_wr_en) |=> !unf_trap);
endmodule

// File: tb/win_ptr_ctrl_tb_top.sv
module win_ptr_ctrl_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        save_req = 0, restore_req = 0, ptr_wr_en = 0, mask_wr_en = 0;
  logic [4:0]  ptr_wr_data = '0;
  logic [31:0] mask_wr_data = '0;
  logic [4:0]  cur_ptr;
  logic        ovf_trap, unf_trap;

  int checks = 0, fails = 0;
  bit started = 0;
  bit done = 0;

  int          m_ptr;
  logic [31:0] m_mask;
  bit          m_ovf, m_unf;
  string       m_tag = "R1";

  always #4 clk = ~clk;

  win_ptr_ctrl #(.NWIN(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .cur_ptr(cur_ptr), .ovf_trap(ovf_trap),
    .unf_trap(unf_trap)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_mask = '0; m_ovf = 0; m_unf = 0; m_tag = "R1";
    end else begin
      int tgt;
      m_ovf = 0; m_unf = 0;
      if (ptr_wr_en || mask_wr_en) begin
        m_tag = "R8";
        if (ptr_wr_en) begin
          if (int'(ptr_wr_data) < N) m_ptr = int'(ptr_wr_data);
          m_tag = "R7";
        end
        if (mask_wr_en) m_mask = mask_wr_data;
        if (save_req || restore_req) m_tag = "R8";
      end else if (save_req) begin
        tgt = (m_ptr + N - 1) % N;
        m_tag = restore_req ? "R9" : "R2";
        if (m_mask[tgt]) begin m_ovf = 1; m_tag = "R4"; end
        else m_ptr = tgt;
      end else if (restore_req) begin
        tgt = (m_ptr + 1) % N;
        m_tag = "R3";
        if (m_mask[tgt]) begin m_unf = 1; m_tag = "R5"; end
        else m_ptr = tgt;
      end else m_tag = "R10";
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(int'(cur_ptr) == m_ptr, m_tag, int'(cur_ptr), m_ptr);
      chk(ovf_trap == m_ovf, m_tag, int'(ovf_trap), int'(m_ovf));
      chk(unf_trap == m_unf, m_tag, int'(unf_trap), int'(m_unf));
    end
  end

  task automatic step(input bit sv, input bit rs, input bit pw, input int pd,
                      input bit mw, input logic [31:0] md);
    save_req = sv; restore_req = rs; ptr_wr_en = pw; ptr_wr_data = 5'(pd);
    mask_wr_en = mw; mask_wr_data = md;
    @(posedge clk); #2;
    save_req = 0; restore_req = 0; ptr_wr_en = 0; mask_wr_en = 0;
  endtask

  task automatic expect_out(input int p, input bit o, input bit u, input string tag);
    chk(int'(cur_ptr) == p, tag, int'(cur_ptr), p);
    chk(ovf_trap == o && unf_trap == u, tag, {ovf_trap, unf_trap}, {o, u});
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 started = 1;
    expect_out(0, 0, 0, "R1");
    step(0, 1, 0, 0, 0, 0); expect_out(1, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0); expect_out(2, 0, 0, "R3");
    step(1, 0, 0, 0, 0, 0); expect_out(1, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0); expect_out(0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0); expect_out(N-1, 0, 0, "R2");
    step(0, 1, 0, 0, 0, 0); expect_out(0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, 32'h80); expect_out(0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, 0); expect_out(0, 1, 0, "R4");
    step(0, 0, 0, 0, 0, 0); expect_out(0, 0, 0, "R4");
    step(0, 0, 1, 6, 0, 0); expect_out(6, 0, 0, "R7");
    step(0, 1, 0, 0, 0, 0); expect_out(6, 0, 1, "R5");
    step(0, 0, 1, 9, 0, 0); expect_out(6, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 32'h100); expect_out(6, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 0); expect_out(7, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 0); expect_out(0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 32'h2); expect_out(0, 0, 0, "R6");
    step(0, 1, 1, 3, 0, 0); expect_out(3, 0, 0, "R8");
    step(1, 0, 0, 0, 1, 32'h4); expect_out(3, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 0); expect_out(3, 1, 0, "R4");
    step(1, 1, 0, 0, 0, 0); expect_out(3, 1, 0, "R9");
    step(0, 0, 0, 0, 1, 32'h0); expect_out(3, 0, 0, "R8");
    step(1, 1, 0, 0, 0, 0); expect_out(2, 0, 0, "R9");
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      logic [31:0] md = (r < 50) ? (32'h1 << ($urandom % 32)) : 32'h0;
      step(($urandom % 2) == 1, ($urandom % 2) == 1, r < 8, int'($urandom % 32),
           r >= 8 && r < 14, md);
    end
    done = 1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule